// File: doc/BRIEF.md
# Defect recovery action dispatcher

This block sits between a set of on-chip defect detectors and the machinery that repairs the effect of a hit. Each detector raises a request and holds it until it is acknowledged. The request carries a defect identifier, a timing class and a location class. The timing class says whether the hit was caught before the faulty effect took place or after it. The location class says where the effect lives.

Requests reach the decision logic through two levels of aggregation. Detectors are grouped under neighbourhood hubs. Each hub picks one pending detector in rotating order and keeps that grant until the global stage accepts it. The global stage runs the same rotation across the hubs, accepts one request at a time and picks the recovery action from the request's classes and from a checkpoint-available input.

The action appears as a one-hot strobe: module reset, pipeline flush, checkpoint rollback or OS interrupt. The strobe is held until the external partner acknowledges it. When execution may simply continue, a disable command carrying the defect identifier is sent back to the detectors.

Top module: `rec_dispatch`

## Requirements
- R1: After reset, all action strobes, `dis_valid` and every `det_ack` bit are low.
- R2: A request with `post`=0 (caught before the effect) drives no action strobe. In the cycle after its acknowledge, it produces a one-cycle `dis_valid` pulse with `dis_id` equal to the request's identifier.
- R3: A request with `post`=1 and location code 2'b00 (one module) raises `act_reset` in the cycle after its acknowledge, with `dis_valid` low.
- R4: A request with `post`=1 and location code 2'b01 (pipeline) raises `act_flush` in the cycle after its acknowledge, with `dis_valid` low.
- R5: A request with `post`=1, location code 2'b10 or 2'b11, and `ckpt_ok` high raises `act_rollback` in the cycle after its acknowledge. In that same cycle it pulses `dis_valid` with the request's identifier.
- R6: A request with `post`=1, location code 2'b10 or 2'b11, and `ckpt_ok` low raises `act_intr` in the cycle after its acknowledge, with `dis_valid` low.
- R7: While an action strobe is high, no detector is acknowledged. A waiting request is served only after `act_ack` has cleared the strobe.
- R8: At most one action strobe is high at any time. An action strobe stays high and unchanged until a cycle with `act_ack` high, and is low in the cycle after that one.
- R9: `ckpt_ok` is sampled at the clock edge that ends the acknowledge cycle. Later changes of `ckpt_ok` do not alter a strobe already raised.
- R10: At most one `det_ack` bit is high per cycle, and only for a detector whose request is high.
- R11: Detector d belongs to hub d / PER_HUB. Each hub, and the global stage across hubs, grants in rotating order, starting from index 0 after reset and continuing from the index after the last one served. With all four detectors of the default configuration requesting from reset, they are served in the order 0, 2, 1, 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| det_req | input | N_HUBS*PER_HUB | Request per detector, held until acknowledged |
| det_id | input | N_HUBS*PER_HUB*ID_W | Defect identifier per detector |
| det_post | input | N_HUBS*PER_HUB | Timing class per detector: 0 before effect, 1 after |
| det_loc | input | 2*N_HUBS*PER_HUB | Location class per detector: 00 module, 01 pipeline, 10/11 other |
| det_ack | output | N_HUBS*PER_HUB | One-cycle acknowledge per detector |
| ckpt_ok | input | 1 | Checkpoint support available |
| act_reset | output | 1 | Module reset strobe |
| act_flush | output | 1 | Pipeline flush strobe |
| act_rollback | output | 1 | Checkpoint rollback strobe |
| act_intr | output | 1 | OS interrupt strobe |
| act_ack | input | 1 | Action partner done, clears the strobe |
| dis_valid | output | 1 | Condition-disable command valid |
| dis_id | output | ID_W | Defect identifier to disable |

## Verification
The bench uses the default configuration: two hubs of two detectors each and 4-bit identifiers. With only four detectors, every detector can be swept against every timing class, every location code and both checkpoint states, 64 cases in all. The small fan-in also makes the full rotation order, starting from reset with all detectors requesting, short enough to predict by hand. The hold and back-pressure behaviour is exercised by keeping a strobe unacknowledged while a second detector waits, and the checkpoint sampling point by flipping `ckpt_ok` before and after the accepting edge.

// File: rtl/rec_pkg.sv
package rec_pkg;

  // action strobe bit positions
  localparam int ACT_RST = 0;
  localparam int ACT_FLS = 1;
  localparam int ACT_RBK = 2;
  localparam int ACT_INT = 3;

  localparam logic [1:0] LOC_MODULE   = 2'b00;
  localparam logic [1:0] LOC_PIPELINE = 2'b01;

  typedef enum logic { ENG_IDLE, ENG_BUSY } eng_state_e;

  // First set request at or after start, wrapping within n entries.
  function automatic int rr_pick(logic [31:0] req, int n, int start);
    int   res;
    int   idx;
    logic found;
    res   = start;
    found = 1'b0;
    for (int k = 0; k < 32; k++) begin
      if (k < n) begin
        idx = start + k;
        if (idx >= n) idx = idx - n;
        if (req[idx[4:0]] && !found) begin
          res   = idx;
          found = 1'b1;
        end
      end
    end
    return res;
  endfunction

  // One-hot recovery action; zero means continue without an action.
  function automatic logic [3:0] pick_action(logic post, logic [1:0] loc, logic ckpt);
    logic [3:0] a;
    a = '0;
    if (post) begin
      if (loc == LOC_MODULE)        a[ACT_RST] = 1'b1;
      else if (loc == LOC_PIPELINE) a[ACT_FLS] = 1'b1;
      else if (ckpt)                a[ACT_RBK] = 1'b1;
      else                          a[ACT_INT] = 1'b1;
    end
    return a;
  endfunction

  // Cases that resume execution and so must switch the condition off.
  function automatic logic needs_disable(logic post, logic [1:0] loc, logic ckpt);
    return !post || (loc[1] && ckpt);
  endfunction

endpackage

// File: rtl/rec_hub.sv
module rec_hub #(
  parameter int N  = 2,
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic [N*PW-1:0] pay,
  output logic          up_req,
  output logic [PW-1:0] up_pay,
  input  logic          up_ack,
  output logic [N-1:0]  dn_ack
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic          locked_q;
  logic [IW-1:0] gnt_q;
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] pick;
  logic          grant_evt;
  logic          release_evt;

  assign pick        = IW'(rec_pkg::rr_pick(32'(req), N, int'(ptr_q)));
  assign grant_evt   = !locked_q && (|req);
  assign release_evt = locked_q && up_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      gnt_q    <= '0;
      ptr_q    <= '0;
    end else if (grant_evt) begin
      locked_q <= 1'b1;
      gnt_q    <= pick;
    end else if (release_evt) begin
      locked_q <= 1'b0;
      ptr_q    <= (gnt_q == IW'(N - 1)) ? '0 : gnt_q + 1'b1;
    end
  end

  assign up_req = locked_q && req[gnt_q];
  assign up_pay = pay[gnt_q*PW +: PW];

  always_comb begin
    dn_ack = '0;
    if (release_evt) dn_ack[gnt_q] = 1'b1;
  end
endmodule

// File: rtl/rec_engine.sv
module rec_engine #(
  parameter int ID_W = 4,
  localparam int PW  = ID_W + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            g_req,
  input  logic [PW-1:0]   g_pay,
  output logic            g_ack,
  input  logic            ckpt_ok,
  output logic [3:0]      act,
  input  logic            act_ack,
  output logic            dis_valid,
  output logic [ID_W-1:0] dis_id
);
  import rec_pkg::*;

  eng_state_e      state_q;
  logic [3:0]      act_q;
  logic            dis_q;
  logic [ID_W-1:0] dis_id_q;
  logic            accept_evt;
  logic            done_evt;
  logic [3:0]      act_next;
  logic            dis_next;

  wire [1:0]      p_loc  = g_pay[1:0];
  wire            p_post = g_pay[2];
  wire [ID_W-1:0] p_id   = g_pay[PW-1:3];

  assign g_ack      = (state_q == ENG_IDLE) && g_req;
  assign accept_evt = g_ack;
  assign done_evt   = (state_q == ENG_BUSY) && act_ack;
  assign act_next   = pick_action(p_post, p_loc, ckpt_ok);
  assign dis_next   = needs_disable(p_post, p_loc, ckpt_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ENG_IDLE;
      act_q    <= '0;
      dis_q    <= 1'b0;
      dis_id_q <= '0;
    end else begin
      dis_q <= 1'b0;
      if (accept_evt) begin
        act_q    <= act_next;
        dis_q    <= dis_next;
        dis_id_q <= p_id;
        state_q  <= (act_next != '0) ? ENG_BUSY : ENG_IDLE;
      end else if (done_evt) begin
        act_q   <= '0;
        state_q <= ENG_IDLE;
      end
    end
  end

  assign act       = act_q;
  assign dis_valid = dis_q;
  assign dis_id    = dis_id_q;
endmodule

// File: rtl/rec_dispatch.sv
module rec_dispatch #(
  parameter int N_HUBS  = 2,
  parameter int PER_HUB = 2,
  parameter int ID_W    = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [N_HUBS*PER_HUB-1:0]         det_req,
  input  logic [N_HUBS*PER_HUB*ID_W-1:0]    det_id,
  input  logic [N_HUBS*PER_HUB-1:0]         det_post,
  input  logic [2*N_HUBS*PER_HUB-1:0]       det_loc,
  output logic [N_HUBS*PER_HUB-1:0]         det_ack,
  input  logic                              ckpt_ok,
  output logic                              act_reset,
  output logic                              act_flush,
  output logic                              act_rollback,
  output logic                              act_intr,
  input  logic                              act_ack,
  output logic                              dis_valid,
  output logic [ID_W-1:0]                   dis_id
);
  import rec_pkg::*;

  localparam int N_DET = N_HUBS * PER_HUB;
  localparam int PW    = ID_W + 3;

  logic [N_DET*PW-1:0]  det_pay;
  logic [N_HUBS-1:0]    hub_req;
  logic [N_HUBS*PW-1:0] hub_pay;
  logic [N_HUBS-1:0]    hub_ack;
  logic                 top_req;
  logic [PW-1:0]        top_pay;
  logic                 top_ack;
  logic [3:0]           act;

  for (genvar d = 0; d < N_DET; d++) begin : g_pay
    assign det_pay[d*PW +: PW] = {det_id[d*ID_W +: ID_W], det_post[d], det_loc[2*d +: 2]};
  end

  for (genvar h = 0; h < N_HUBS; h++) begin : g_hub
    rec_hub #(.N(PER_HUB), .PW(PW)) u_hub (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (det_req[h*PER_HUB +: PER_HUB]),
      .pay    (det_pay[h*PER_HUB*PW +: PER_HUB*PW]),
      .up_req (hub_req[h]),
      .up_pay (hub_pay[h*PW +: PW]),
      .up_ack (hub_ack[h]),
      .dn_ack (det_ack[h*PER_HUB +: PER_HUB])
    );
  end

  rec_hub #(.N(N_HUBS), .PW(PW)) u_global_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (hub_req),
    .pay    (hub_pay),
    .up_req (top_req),
    .up_pay (top_pay),
    .up_ack (top_ack),
    .dn_ack (hub_ack)
  );

  rec_engine #(.ID_W(ID_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .g_req     (top_req),
    .g_pay     (top_pay),
    .g_ack     (top_ack),
    .ckpt_ok   (ckpt_ok),
    .act       (act),
    .act_ack   (act_ack),
    .dis_valid (dis_valid),
    .dis_id    (dis_id)
  );

  assign act_reset    = act[ACT_RST];
  assign act_flush    = act[ACT_FLS];
  assign act_rollback = act[ACT_RBK];
  assign act_intr     = act[ACT_INT];
endmodule

// File: rtl/rec_dispatch_chk.sv
module rec_dispatch_chk #(
  parameter int N_DET = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_DET-1:0] det_req,
  input logic [N_DET-1:0] det_ack,
  input logic             act_reset,
  input logic             act_flush,
  input logic             act_rollback,
  input logic             act_intr,
  input logic             act_ack,
  input logic             dis_valid
);
  wire [3:0] act_v  = {act_intr, act_rollback, act_flush, act_reset};
  wire       act_on = |act_v;

  // R8
  act_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_v));

  // R8
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_on && !act_ack) |=> $stable(act_v));

  // R8
  act_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_on && act_ack) |=> !act_on);

  // R7
  no_ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_on |-> (det_ack == '0));

  // R10
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(det_ack) && ((det_ack & ~det_req) == '0));

  // R2
  dis_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_valid |=> !dis_valid);

  // R5
  rollback_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_rollback) |-> dis_valid);

  // R3
  reset_no_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_reset) |-> !dis_valid);
endmodule

bind rec_dispatch rec_dispatch_chk #(.N_DET(N_HUBS*PER_HUB)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .det_req      (det_req),
  .det_ack      (det_ack),
  .act_reset    (act_reset),
  .act_flush    (act_flush),
  .act_rollback (act_rollback),
  .act_intr     (act_intr),
  .act_ack      (act_ack),
  .dis_valid    (dis_valid)
);

// File: tb/rec_dispatch_tb.sv
`timescale 1ns/1ps
module rec_dispatch_tb;
  localparam int NH = 2;
  localparam int PH = 2;
  localparam int IDW = 4;
  localparam int ND = NH * PH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ND-1:0]     det_req  = '0;
  logic [ND*IDW-1:0] det_id   = '0;
  logic [ND-1:0]     det_post = '0;
  logic [2*ND-1:0]   det_loc  = '0;
  logic [ND-1:0]     det_ack;
  logic ckpt_ok = 1'b0;
  logic act_reset, act_flush, act_rollback, act_intr;
  logic act_ack = 1'b0;
  logic dis_valid;
  logic [IDW-1:0] dis_id;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  rec_dispatch #(.N_HUBS(NH), .PER_HUB(PH), .ID_W(IDW)) u_dut (
    .clk(clk), .rst_n(rst_n), .det_req(det_req), .det_id(det_id),
    .det_post(det_post), .det_loc(det_loc), .det_ack(det_ack),
    .ckpt_ok(ckpt_ok), .act_reset(act_reset), .act_flush(act_flush),
    .act_rollback(act_rollback), .act_intr(act_intr), .act_ack(act_ack),
    .dis_valid(dis_valid), .dis_id(dis_id)
  );

  function automatic logic [3:0] acts();
    return {act_intr, act_rollback, act_flush, act_reset};
  endfunction

  task automatic check(bit ok, string tag, int act_v, int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic set_det(int d, bit post, logic [1:0] loc, logic [IDW-1:0] id);
    det_post[d]          = post;
    det_loc[2*d +: 2]    = loc;
    det_id[d*IDW +: IDW] = id;
  endtask

  task automatic wait_ack(int d, output bit seen);
    seen = 1'b0;
    for (int c = 0; c < 30 && !seen; c++) begin
      @(negedge clk);
      if (det_ack[d]) seen = 1'b1;
    end
  endtask

  task automatic finish_action();
    act_ack = 1'b1;
    @(posedge clk); #1;
    act_ack = 1'b0;
  endtask

  task automatic run_case(int d, bit post, logic [1:0] loc, bit ck, logic [IDW-1:0] id);
    bit seen;
    logic [3:0] exp_a;
    bit exp_d;
    string tag;
    if (!post) begin exp_a = 4'b0000; tag = "R2"; end
    else if (loc == 2'b00) begin exp_a = 4'b0001; tag = "R3"; end
    else if (loc == 2'b01) begin exp_a = 4'b0010; tag = "R4"; end
    else if (ck) begin exp_a = 4'b0100; tag = "R5"; end
    else begin exp_a = 4'b1000; tag = "R6"; end
    exp_d = !post || (post && loc >= 2'b10 && ck);
    @(negedge clk);
    set_det(d, post, loc, id);
    ckpt_ok = ck;
    det_req[d] = 1'b1;
    wait_ack(d, seen);
    check(seen, "R10 ack seen", int'(seen), 1);
    @(posedge clk); #1;
    det_req[d] = 1'b0;
    @(negedge clk);
    check(acts() == exp_a, tag, int'(acts()), int'(exp_a));
    check(dis_valid == exp_d, tag, int'(dis_valid), int'(exp_d));
    if (exp_d) check(dis_id == id, tag, int'(dis_id), int'(id));
    if (exp_a != 0) begin
      ckpt_ok = !ck;
      @(negedge clk);
      check(acts() == exp_a, "R8 hold", int'(acts()), int'(exp_a));
      check(!dis_valid, "R2 pulse", int'(dis_valid), 0);
      finish_action();
      @(negedge clk);
      check(acts() == 0, "R8 clear", int'(acts()), 0);
    end else begin
      @(negedge clk);
      check(!dis_valid, "R2 pulse", int'(dis_valid), 0);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    det_req = '0;
    act_ack = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    bit seen;
    do_reset();
    @(negedge clk);
    // R1
    check(acts() == 0, "R1 strobes", int'(acts()), 0);
    check(!dis_valid, "R1 dis", int'(dis_valid), 0);
    check(det_ack == 0, "R1 ack", int'(det_ack), 0);

    // Sweep: every detector x timing x location x checkpoint
    for (int d = 0; d < ND; d++)
      for (int p = 0; p < 2; p++)
        for (int l = 0; l < 4; l++)
          for (int k = 0; k < 2; k++)
            run_case(d, p[0], l[1:0], k[0], IDW'(d * 5 + l * 3 + p + k));

    // R9: ckpt_ok sampled at accepting edge
    @(negedge clk);
    set_det(1, 1'b1, 2'b10, 4'h9);
    ckpt_ok = 1'b0;
    det_req[1] = 1'b1;
    wait_ack(1, seen);
    ckpt_ok = 1'b1;
    @(posedge clk); #1;
    det_req[1] = 1'b0;
    ckpt_ok = 1'b0;
    @(negedge clk);
    check(acts() == 4'b0100, "R9 sample", int'(acts()), 4);
    check(dis_valid && dis_id == 4'h9, "R9 dis", int'(dis_id), 9);
    @(negedge clk);
    check(acts() == 4'b0100, "R9 hold", int'(acts()), 4);
    finish_action();

    // R7: back-pressure while an action is outstanding
    @(negedge clk);
    set_det(0, 1'b1, 2'b00, 4'h3);
    det_req[0] = 1'b1;
    wait_ack(0, seen);
    @(posedge clk); #1;
    det_req[0] = 1'b0;
    set_det(3, 1'b0, 2'b00, 4'hC);
    det_req[3] = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      check(det_ack == 0 && act_reset, "R7 busy", int'(det_ack), 0);
    end
    finish_action();
    wait_ack(3, seen);
    check(seen, "R7 served after", int'(seen), 1);
    @(posedge clk); #1;
    det_req[3] = 1'b0;
    @(negedge clk);
    check(dis_valid && dis_id == 4'hC, "R7 dis", int'(dis_id), 12);

    // R11: rotation order from reset, all requesting
    do_reset();
    @(negedge clk);
    for (int d = 0; d < ND; d++) set_det(d, 1'b0, 2'b00, IDW'(d + 1));
    det_req = '1;
    for (int k = 0; k < ND; k++) begin
      int exp_d;
      int got;
      exp_d = (k % NH) * PH + (k / NH);
      got = -1;
      for (int c = 0; c < 30 && got < 0; c++) begin
        @(negedge clk);
        for (int d = 0; d < ND; d++) if (det_ack[d]) got = d;
      end
      check(got == exp_d, "R11 order", got, exp_d);
      @(posedge clk); #1;
      if (got >= 0) det_req[got] = 1'b0;
    end
    det_req = '0;
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule